// File: doc/BRIEF.md
# Memory-Mapped I/O Address Router

This block sits on the load/store port of a small processor. It sends each single-word access to one of two targets. An access whose top address bit is clear goes to main memory, which answers with a fixed latency. An access whose top address bit is set is meant for one of several peripheral controllers. Each controller owns a fixed 256-byte window, starting at the base of the upper half of the address space. For such an access the block issues a request message on an I/O bus. The message carries the read/write flag, the controller index, the byte offset inside the window and the write data. The block then holds the processor until that controller acknowledges.

Boot code marks which windows are populated by writing a window-enable mask. An upper-half access that does not land in an enabled window completes at once with an error flag and zero data. Nothing is sent downstream in that case.

The processor side is a valid/ready request channel with a response pulse:

- The processor holds `cpu_req_valid` and its payload until it sees `cpu_req_ready` high at a clock edge.
- The router accepts only one access at a time. `cpu_req_ready` stays low from the accept edge until the cycle after the response.
- The response is a one-cycle pulse on `cpu_rsp_valid`, and the processor must take it in that cycle.
- On the I/O bus the router holds `io_req_valid` and the message until the bus raises `io_req_ready`.

Top module: `mmio_router`

## Requirements
- R1: After reset the router is idle: `cpu_req_ready` is 1, `cpu_rsp_valid`, `mem_req_valid` and `io_req_valid` are 0, and every window is disabled.
- R2: An access with address bit 31 = 0 drives `mem_req_valid` for exactly one cycle, the cycle after the accept edge. It carries the address, write flag and data unchanged. The response comes in the next cycle with `mem_rdata` and `cpu_rsp_err` = 0. No I/O request is made.
- R3: An access with bit 31 = 1 whose window index (address bits 30:8) is below 8 and enabled sends one I/O request. The message has `io_req_ctrl` = address bits 10:8, `io_req_offset` = address bits 7:0, `io_req_write` = the write flag and the write data. Memory is not touched.
- R4: `io_req_valid` rises the cycle after the accept edge. It and the whole message stay constant until a cycle in which `io_req_ready` is 1.
- R5: After the request handshake the router waits for `io_ack_valid`. The response follows one cycle after the acknowledge and carries `io_ack_rdata`, with error 0. An acknowledge seen before the handshake is ignored.
- R6: An upper-half access to a disabled window, or to a window index of 8 or more, responds the cycle after the accept edge with `cpu_rsp_err` = 1 and zero read data. It issues no memory or I/O request.
- R7: A cycle with `cfg_we` = 1 loads `cfg_win_mask`, where bit n enables window n. The new mask governs every access accepted after that edge.
- R8: At most one access is in flight. `cpu_req_ready` is 0 from the accept edge through the response cycle, returns to 1 the cycle after, and `cpu_rsp_valid` is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the window-enable mask |
| cfg_win_mask | input | 8 | Window-enable mask, bit n for window n |
| cpu_req_valid | input | 1 | Processor access request valid |
| cpu_req_ready | output | 1 | Router can accept an access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Load data |
| cpu_rsp_err | output | 1 | Access hit no enabled window |
| mem_req_valid | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the strobe |
| io_req_valid | output | 1 | I/O request message valid |
| io_req_ready | input | 1 | I/O bus takes the message |
| io_req_write | output | 1 | Message is a write |
| io_req_ctrl | output | 3 | Target controller index |
| io_req_offset | output | 8 | Byte offset inside the window |
| io_req_wdata | output | 32 | Message write data |
| io_ack_valid | input | 1 | Controller acknowledge |
| io_ack_rdata | input | 32 | Controller read data with the acknowledge |

## Verification
The assertions check on every cycle:

- memory and I/O strobes never overlap, and a memory strobe is always followed by a clean response;
- a stalled I/O message keeps its payload;
- an error response carries zero data;
- a new access is never accepted while one is in flight, and a response never lasts two cycles.

Only the bench scenarios can show the rest. These cover routing by address across every window under several enable masks, including the indices beyond the eighth window, and the exact field values in each message. They also cover data round trips through memory and controllers, and latencies under varied ready and acknowledge delays. The last scenarios show that a stray early acknowledge and a mask rewrite between accesses have the intended effect.

// File: rtl/mmio_router_pkg.sv
`timescale 1ns/1ps
package mmio_router_pkg;
  typedef enum logic [1:0] {RT_MEM, RT_IO, RT_ERR} route_t;
  typedef enum logic [2:0] {
    S_IDLE, S_MEM, S_MEM_RSP, S_IO_REQ, S_IO_WAIT, S_IO_RSP, S_ERR_RSP
  } state_t;
endpackage

// File: rtl/mmio_window_cfg.sv
`timescale 1ns/1ps
module mmio_window_cfg #(
  parameter int NUM_WIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [NUM_WIN-1:0] cfg_mask,
  output logic [NUM_WIN-1:0] win_en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      win_en <= '0;
    else if (cfg_we) win_en <= cfg_mask;
  end
endmodule

// File: rtl/mmio_addr_decode.sv
`timescale 1ns/1ps
module mmio_addr_decode
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_LOG2 = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_WIN-1:0]  win_en,
  output route_t              route,
  output logic [IDX_W-1:0]    ctrl_idx,
  output logic [WIN_LOG2-1:0] offset
);
  localparam int FIELD_W = ADDR_W - 1 - WIN_LOG2;

  logic [FIELD_W-1:0] win_field;
  logic [NUM_WIN-1:0] hit;
  logic               io_hit;

  assign win_field = addr[ADDR_W-2:WIN_LOG2];

  // one comparator per window: the index must match and the window be enabled
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    assign hit[n] = win_en[n] && (win_field == FIELD_W'(n));
  end

  assign io_hit   = |hit;
  assign ctrl_idx = win_field[IDX_W-1:0];
  assign offset   = addr[WIN_LOG2-1:0];

  always_comb begin
    if (!addr[ADDR_W-1]) route = RT_MEM;
    else if (io_hit)     route = RT_IO;
    else                 route = RT_ERR;
  end
endmodule

// File: rtl/mmio_xfer_seq.sv
`timescale 1ns/1ps
module mmio_xfer_seq
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_LOG2 = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  route_t              route,
  input  logic [IDX_W-1:0]    ctrl_idx,
  input  logic [WIN_LOG2-1:0] offset,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_rdata,
  output logic                cpu_rsp_err,
  output logic                mem_req_valid,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                io_req_valid,
  input  logic                io_req_ready,
  output logic                io_req_write,
  output logic [IDX_W-1:0]    io_req_ctrl,
  output logic [WIN_LOG2-1:0] io_req_offset,
  output logic [DATA_W-1:0]   io_req_wdata,
  input  logic                io_ack_valid,
  input  logic [DATA_W-1:0]   io_ack_rdata
);
  state_t              state;
  logic                we_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [IDX_W-1:0]    ctrl_q;
  logic [WIN_LOG2-1:0] off_q;
  logic [DATA_W-1:0]   rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ctrl_q  <= '0;
      off_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (cpu_req_valid) begin
          we_q    <= cpu_we;
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          ctrl_q  <= ctrl_idx;
          off_q   <= offset;
          unique case (route)
            RT_MEM:  state <= S_MEM;
            RT_IO:   state <= S_IO_REQ;
            default: state <= S_ERR_RSP;
          endcase
        end
        S_MEM:     state <= S_MEM_RSP;
        S_IO_REQ:  if (io_req_ready) state <= S_IO_WAIT;
        S_IO_WAIT: if (io_ack_valid) begin
          rdata_q <= io_ack_rdata;
          state   <= S_IO_RSP;
        end
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state == S_IDLE);
  assign cpu_rsp_valid = (state == S_MEM_RSP) || (state == S_IO_RSP) ||
                         (state == S_ERR_RSP);
  assign cpu_rsp_err   = (state == S_ERR_RSP);
  assign cpu_rsp_rdata = (state == S_MEM_RSP) ? mem_rdata :
                         (state == S_IO_RSP)  ? rdata_q   : '0;

  assign mem_req_valid = (state == S_MEM);
  assign mem_we        = we_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;

  assign io_req_valid  = (state == S_IO_REQ);
  assign io_req_write  = we_q;
  assign io_req_ctrl   = ctrl_q;
  assign io_req_offset = off_q;
  assign io_req_wdata  = wdata_q;
endmodule

// File: rtl/mmio_router.sv
`timescale 1ns/1ps
module mmio_router
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_LOG2 = 8,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NUM_WIN-1:0]  cfg_win_mask,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_rdata,
  output logic                cpu_rsp_err,
  output logic                mem_req_valid,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                io_req_valid,
  input  logic                io_req_ready,
  output logic                io_req_write,
  output logic [IDX_W-1:0]    io_req_ctrl,
  output logic [WIN_LOG2-1:0] io_req_offset,
  output logic [DATA_W-1:0]   io_req_wdata,
  input  logic                io_ack_valid,
  input  logic [DATA_W-1:0]   io_ack_rdata
);
  logic [NUM_WIN-1:0]  win_en;
  route_t              route;
  logic [IDX_W-1:0]    ctrl_idx;
  logic [WIN_LOG2-1:0] offset;

  mmio_window_cfg #(.NUM_WIN(NUM_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_win_mask),
    .win_en(win_en)
  );

  mmio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)
  ) u_dec (
    .addr(cpu_addr), .win_en(win_en), .route(route),
    .ctrl_idx(ctrl_idx), .offset(offset)
  );

  mmio_xfer_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .route(route), .ctrl_idx(ctrl_idx), .offset(offset),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_err(cpu_rsp_err),
    .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_ctrl(io_req_ctrl),
    .io_req_offset(io_req_offset), .io_req_wdata(io_req_wdata),
    .io_ack_valid(io_ack_valid), .io_ack_rdata(io_ack_rdata)
  );
endmodule

// File: rtl/mmio_router_chk.sv
`timescale 1ns/1ps
module mmio_router_chk #(
  parameter int DATA_W   = 32,
  parameter int WIN_LOG2 = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_req_valid,
  input logic                cpu_req_ready,
  input logic                cpu_rsp_valid,
  input logic                cpu_rsp_err,
  input logic [DATA_W-1:0]   cpu_rsp_rdata,
  input logic                mem_req_valid,
  input logic                io_req_valid,
  input logic                io_req_ready,
  input logic                io_req_write,
  input logic [IDX_W-1:0]    io_req_ctrl,
  input logic [WIN_LOG2-1:0] io_req_offset,
  input logic [DATA_W-1:0]   io_req_wdata
);
  assert_mem_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !io_req_valid);

  assert_mem_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> (cpu_rsp_valid && !cpu_rsp_err));

  assert_io_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && !io_req_ready) |=>
      (io_req_valid && $stable(io_req_ctrl) && $stable(io_req_offset) &&
       $stable(io_req_write) && $stable(io_req_wdata)));

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_rsp_err) |-> (cpu_rsp_rdata == '0));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
endmodule

bind mmio_router mmio_router_chk #(
  .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err),
  .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
  .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
  .io_req_write(io_req_write), .io_req_ctrl(io_req_ctrl),
  .io_req_offset(io_req_offset), .io_req_wdata(io_req_wdata)
);

// File: tb/sim_mmio_router.sv
`timescale 1ns/1ps
module sim_mmio_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_win_mask = '0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_err;
  logic        mem_req_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        io_req_valid, io_req_ready, io_req_write;
  logic [2:0]  io_req_ctrl;
  logic [7:0]  io_req_offset;
  logic [31:0] io_req_wdata;
  logic        io_ack_valid;
  logic [31:0] io_ack_rdata;

  always #2.5 clk = ~clk;

  mmio_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win_mask(cfg_win_mask),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_err(cpu_rsp_err),
    .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_write(io_req_write), .io_req_ctrl(io_req_ctrl),
    .io_req_offset(io_req_offset), .io_req_wdata(io_req_wdata),
    .io_ack_valid(io_ack_valid), .io_ack_rdata(io_ack_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model: 16 words, read data registered one cycle after the strobe
  logic [31:0] mem_arr [16];
  int          mem_cnt = 0;
  logic [31:0] last_mem_addr = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rdata <= '0;
      for (int i = 0; i < 16; i++) mem_arr[i] <= '0;
    end else if (mem_req_valid) begin
      mem_cnt       <= mem_cnt + 1;
      last_mem_addr <= mem_addr;
      if (mem_we) begin
        mem_arr[mem_addr[5:2]] <= mem_wdata;
        mem_rdata <= '0;
      end else begin
        mem_rdata <= mem_arr[mem_addr[5:2]];
      end
    end
  end

  // controller model: 8 controllers, 4 registers each, programmable delays
  logic [31:0] creg [8][4];
  int          rdy_dly = 0;
  int          ack_dly = 0;
  bit          stray_en = 0;
  int          rcnt = 0;
  int          acnt = 0;
  bit          pend = 0;
  logic [2:0]  rd_ctrl = '0;
  logic [1:0]  rd_idx = '0;
  int          io_cnt = 0;
  logic [2:0]  last_ctrl = '0;
  logic [7:0]  last_off = '0;
  logic        last_write = 1'b0;
  logic [31:0] last_wdata = '0;
  logic        real_ack;

  assign io_req_ready = io_req_valid && (rcnt >= rdy_dly);
  assign real_ack     = pend && (acnt == 0);
  assign io_ack_valid = real_ack | (stray_en && io_req_valid && !io_req_ready);
  assign io_ack_rdata = real_ack ? creg[rd_ctrl][rd_idx] : 32'hBAD0_BAD0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= 0;
      pend <= 0;
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 4; r++) creg[c][r] <= '0;
    end else begin
      if (io_req_valid && !io_req_ready) rcnt <= rcnt + 1;
      else rcnt <= 0;
      if (io_req_valid && io_req_ready) begin
        io_cnt     <= io_cnt + 1;
        last_ctrl  <= io_req_ctrl;
        last_off   <= io_req_offset;
        last_write <= io_req_write;
        last_wdata <= io_req_wdata;
        if (io_req_write) creg[io_req_ctrl][io_req_offset[3:2]] <= io_req_wdata;
        rd_ctrl <= io_req_ctrl;
        rd_idx  <= io_req_offset[3:2];
        pend    <= 1;
        acnt    <= ack_dly;
      end else if (pend) begin
        if (acnt == 0) pend <= 0;
        else acnt <= acnt - 1;
      end
    end
  end

  // route: 0 memory, 1 I/O, 2 error
  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [31:0] wdata, input int route,
                        input logic [31:0] exp_rd, input int exp_lat);
    int n;
    int m0, i0;
    @(negedge clk);
    chk(cpu_req_ready === 1'b1, "R8 ready before access", 32'(cpu_req_ready), 1);
    cpu_req_valid = 1'b1;
    cpu_we        = we;
    cpu_addr      = addr;
    cpu_wdata     = wdata;
    m0 = mem_cnt;
    i0 = io_cnt;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    n = 1;
    while (!cpu_rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    case (route)
      0: chk(n == exp_lat, "R2 memory latency", 32'(n), 32'(exp_lat));
      1: chk(n == exp_lat, "R5 io latency", 32'(n), 32'(exp_lat));
      default: chk(n == exp_lat, "R6 error latency", 32'(n), 32'(exp_lat));
    endcase
    chk(cpu_rsp_err === (route == 2), "R6 error flag", 32'(cpu_rsp_err),
        32'(route == 2));
    if (route == 2)
      chk(cpu_rsp_rdata === 32'h0, "R6 zero data", cpu_rsp_rdata, 0);
    else if (!we)
      chk(cpu_rsp_rdata === exp_rd, route == 0 ? "R2 read data" : "R5 read data",
          cpu_rsp_rdata, exp_rd);
    chk(mem_cnt - m0 == (route == 0 ? 1 : 0), "R2 memory strobe count",
        32'(mem_cnt - m0), 32'(route == 0));
    chk(io_cnt - i0 == (route == 1 ? 1 : 0), "R3 io request count",
        32'(io_cnt - i0), 32'(route == 1));
    if (route == 0)
      chk(last_mem_addr === addr, "R2 memory address", last_mem_addr, addr);
    if (route == 1) begin
      chk(last_ctrl === addr[10:8], "R3 ctrl field", 32'(last_ctrl), 32'(addr[10:8]));
      chk(last_off === addr[7:0], "R3 offset field", 32'(last_off), 32'(addr[7:0]));
      chk(last_write === we, "R3 write flag", 32'(last_write), 32'(we));
      if (we) chk(last_wdata === wdata, "R3 write data", last_wdata, wdata);
    end
    chk(cpu_req_ready === 1'b0, "R8 busy in response", 32'(cpu_req_ready), 0);
    @(negedge clk);
    chk(cpu_rsp_valid === 1'b0, "R8 single pulse", 32'(cpu_rsp_valid), 0);
    chk(cpu_req_ready === 1'b1, "R8 ready after", 32'(cpu_req_ready), 1);
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_win_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] masks [5];
    logic [7:0] offs [2];
    masks = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};
    offs  = '{8'h00, 8'hFC};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready === 1'b1, "R1 ready", 32'(cpu_req_ready), 1);
    chk(cpu_rsp_valid === 1'b0, "R1 no response", 32'(cpu_rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1 no mem strobe", 32'(mem_req_valid), 0);
    chk(io_req_valid === 1'b0, "R1 no io request", 32'(io_req_valid), 0);
    // R1/R7: windows disabled after reset
    access(1'b0, 32'h8000_0000, 0, 2, 0, 1);

    // R2 memory sweep, write low words then read back through high aliases
    for (int i = 0; i < 16; i++)
      access(1'b1, 32'(i * 4), 32'h1357_0000 + 32'(i * 17), 0, 0, 2);
    for (int i = 0; i < 16; i++)
      access(1'b0, 32'h7FFF_FFC0 + 32'(i * 4), 0, 0,
             32'h1357_0000 + 32'(i * 17), 2);

    // R3 R4 R5 R6 R7: window sweep under several masks and delays
    for (int mi = 0; mi < 5; mi++) begin
      set_mask(masks[mi]);
      for (int w = 0; w < 10; w++) begin
        for (int oi = 0; oi < 2; oi++) begin
          logic [31:0] a, d;
          int rt, lat;
          a = 32'h8000_0000 + 32'(w * 256) + 32'(offs[oi]);
          d = 32'hA500_0000 ^ 32'(w << 8) ^ 32'(offs[oi]) ^ (32'(masks[mi]) << 16);
          rt = (w < 8 && masks[mi][w % 8]) ? 1 : 2;
          rdy_dly = w % 3;
          ack_dly = (w + 1) % 4;
          lat = (rt == 1) ? 3 + rdy_dly + ack_dly : 1;
          access(1'b1, a, d, rt, 0, lat);
          access(1'b0, a, 0, rt, d, lat);
        end
      end
    end

    // R5: stray acknowledge while the request waits for ready is ignored
    set_mask(8'h08);
    rdy_dly = 3;
    ack_dly = 1;
    access(1'b1, 32'h8000_0304, 32'hCAFE_F00D, 1, 0, 7);
    stray_en = 1;
    access(1'b0, 32'h8000_0304, 0, 1, 32'hCAFE_F00D, 7);
    stray_en = 0;

    // R7: mask rewrite between accesses takes effect
    set_mask(8'h01);
    rdy_dly = 0;
    ack_dly = 0;
    access(1'b1, 32'h8000_0008, 32'h0F0F_0F0F, 1, 0, 3);
    set_mask(8'h00);
    access(1'b0, 32'h8000_0008, 0, 2, 0, 1);
    set_mask(8'h01);
    access(1'b0, 32'h8000_0008, 0, 1, 32'h0F0F_0F0F, 3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule